// File: doc/BRIEF.md
# Open-Row Page-Mode DRAM Controller

This block sits between a CPU-side request port and a rank of eight byte-wide DRAM devices. The CPU issues 64-bit word reads and writes with a valid/ready handshake. The controller splits the word address into a row index and a column index and puts them, one after the other, on a single address bus that all eight devices share. Device k carries byte k of the word, so a write is split across the lanes and a read is put back together from them.

The controller leaves the most recently used row open. A request to that same row needs only a column strobe. A request to any other row first precharges the open row, then activates the new one, and then issues the column strobe. A refresh timer whose interval is a parameter raises a refresh request. Refresh takes priority over new requests: the open row is closed, and a row-strobe-only cycle refreshes the next row in a rotating sequence.

Top module: `pageDramCtrl`

## Requirements
- R1: The row index is reqAddr[ROW_W+COL_W-1:COL_W] and the column index is reqAddr[COL_W-1:0]. The row appears on dramAddr in the activation cycle and the column, zero-extended, in the column cycle. All devices share the same address.
- R2: Device k (k = 0..7) stores and returns bits [8k+7:8k] of the 64-bit word on dramWrData/dramRdData lane k. A word read back equals the word last written to that address.
- R3: dramCasN is low only while dramRasN is low and was also low in the previous cycle.
- R4: A request that hits the open row produces no new activation. A read hit raises rspValid in the 2nd cycle after the accepting edge.
- R5: A request to a different row gives one precharge cycle (dramRasN high), one activation cycle, and then the column cycle. A read miss with a row open returns in the 4th cycle after acceptance, and a read with no row open returns in the 3rd.
- R6: Refresh is raised every REF_INTERVAL cycles. Each refresh is a row-strobe-only cycle, with no column strobe, on row 0, 1, 2, ... in turn, wrapping after the last row. The row is closed afterwards.
- R7: While a refresh is pending, reqReady is low and no request is accepted. A pending refresh is served within 8 cycles.
- R8: After reset, reqReady is high and dramRasN, dramCasN and dramWeN are high. reqReady is high only while the controller is idle (row open or closed) with no refresh pending, so it is low while a column, activation, precharge or refresh cycle is in progress.
- R9: rspValid is a one-cycle pulse in the cycle after a read column cycle, carrying the assembled word. Writes produce no response.
- R10: dramWeN is low only during a write column cycle, and dramWrData carries the write word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W | Word address {row, column} |
| reqWdata | input | LANES*LANE_W | Write word |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | LANES*LANE_W | Assembled read word |
| dramAddr | output | max(ROW_W,COL_W) | Shared device address bus |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramWrData | output | LANES*LANE_W | Per-device write bytes, lane k = device k |
| dramRdData | input | LANES*LANE_W | Per-device read bytes, lane k = device k |

## Verification
The bench builds the controller with 3-bit row and 3-bit column indices and a refresh interval of 40 cycles. This gives a 64-word array that random traffic covers completely, makes row hits and row misses both frequent, and lets the refresh row counter wrap several times in a short run. A behavioural model of the eight devices tracks the open row from the strobes. The bench uses this model to predict the latency of each read, to verify the refresh row order, and to check each stored byte lane.

// File: rtl/pageDramPkg.sv
package pageDramPkg;

  typedef enum logic [1:0] {
    ADDR_NONE,
    ADDR_ROW,
    ADDR_COL,
    ADDR_REF
  } addrSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPENED,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_REF
  } ctlState_e;

  // Strobes from control to datapath and device pins
  typedef struct packed {
    logic     loadReq;
    logic     setOpenRow;
    logic     stepRefRow;
    logic     capture;
    addrSel_e addrSel;
    logic     rasN;
    logic     casN;
    logic     weN;
  } ctlStrobes_t;

endpackage

// File: rtl/pageDramCtl.sv
module pageDramCtl
  import pageDramPkg::*;
#(
  parameter int REF_INTERVAL = 1560
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqHit,
  input  logic        curWrite,
  output logic        reqReady,
  output logic        refPending,
  output ctlStrobes_t ctl
);

  localparam int TW = $clog2(REF_INTERVAL + 1);

  ctlState_e state, stateNxt;
  logic [TW-1:0] refTimer;
  logic busy;
  logic accept;

  assign reqReady = ((state == ST_IDLE) || (state == ST_OPENED)) && !refPending;
  assign accept   = reqValid && reqReady;

  // Refresh interval timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      if (ctl.stepRefRow) refPending <= 1'b0;
      if (refTimer == TW'(REF_INTERVAL - 1)) begin
        refTimer   <= '0;
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) busy <= 1'b1;
      else if (state == ST_COL) busy <= 1'b0;
    end
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (refPending) stateNxt = ST_REF;
                 else if (accept) stateNxt = ST_ACT;
      ST_OPENED: if (refPending) stateNxt = ST_PRE;
                 else if (accept) stateNxt = reqHit ? ST_COL : ST_PRE;
      ST_PRE:    stateNxt = busy ? ST_ACT : ST_REF;
      ST_ACT:    stateNxt = ST_COL;
      ST_COL:    stateNxt = ST_OPENED;
      ST_REF:    stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl = '{loadReq: accept, setOpenRow: 1'b0, stepRefRow: 1'b0, capture: 1'b0,
            addrSel: ADDR_NONE, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
    unique case (state)
      ST_OPENED: ctl.rasN = 1'b0;
      ST_ACT: begin
        ctl.rasN       = 1'b0;
        ctl.addrSel    = ADDR_ROW;
        ctl.setOpenRow = 1'b1;
      end
      ST_COL: begin
        ctl.rasN    = 1'b0;
        ctl.casN    = 1'b0;
        ctl.weN     = !curWrite;
        ctl.capture = !curWrite;
        ctl.addrSel = ADDR_COL;
      end
      ST_REF: begin
        ctl.rasN       = 1'b0;
        ctl.addrSel    = ADDR_REF;
        ctl.stepRefRow = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pageDramDp.sv
module pageDramDp
  import pageDramPkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               ctl,
  input  logic                      reqWrite,
  input  logic [ROW_W+COL_W-1:0]    reqAddr,
  input  logic [LANES*LANE_W-1:0]   reqWdata,
  input  logic [LANES*LANE_W-1:0]   dramRdData,
  output logic                      reqHit,
  output logic                      curWrite,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [LANES*LANE_W-1:0]   dramWrData,
  output logic                      rspValid,
  output logic [LANES*LANE_W-1:0]   rspData
);

  localparam int DA = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int AW = ROW_W + COL_W;

  logic [ROW_W-1:0] rowReg, openRow, refRow;
  logic [COL_W-1:0] colReg;
  logic [LANES*LANE_W-1:0] wdataReg;
  logic [LANE_W-1:0] rdLane [LANES];

  assign reqHit = (reqAddr[AW-1:COL_W] == openRow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openRow  <= '0;
      refRow   <= '0;
      curWrite <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= ctl.capture;
      if (ctl.loadReq) begin
        rowReg   <= reqAddr[AW-1:COL_W];
        colReg   <= reqAddr[COL_W-1:0];
        curWrite <= reqWrite;
        wdataReg <= reqWdata;
      end
      if (ctl.setOpenRow) openRow <= rowReg;
      if (ctl.stepRefRow) refRow <= refRow + 1'b1;
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      ADDR_ROW: dramAddr = DA'(rowReg);
      ADDR_COL: dramAddr = DA'(colReg);
      ADDR_REF: dramAddr = DA'(refRow);
      default:  dramAddr = '0;
    endcase
  end

  // Byte-lane striping: device k owns slice k of the word
  for (genvar k = 0; k < LANES; k++) begin : gLane
    assign dramWrData[k*LANE_W +: LANE_W] = wdataReg[k*LANE_W +: LANE_W];
    always_ff @(posedge clk) begin
      if (ctl.capture) rdLane[k] <= dramRdData[k*LANE_W +: LANE_W];
    end
    assign rspData[k*LANE_W +: LANE_W] = rdLane[k];
  end

endmodule

// File: rtl/pageDramCtrl.sv
module pageDramCtrl
  import pageDramPkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int LANES        = 8,
  parameter int LANE_W       = 8,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ROW_W+COL_W-1:0]  reqAddr,
  input  logic [LANES*LANE_W-1:0] reqWdata,
  output logic                    rspValid,
  output logic [LANES*LANE_W-1:0] rspData,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic                    dramRasN,
  output logic                    dramCasN,
  output logic                    dramWeN,
  output logic [LANES*LANE_W-1:0] dramWrData,
  input  logic [LANES*LANE_W-1:0] dramRdData
);

  ctlStrobes_t ctl;
  logic reqHit, curWrite, refPending;

  pageDramCtl #(.REF_INTERVAL(REF_INTERVAL)) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHit(reqHit),
    .curWrite(curWrite), .reqReady(reqReady), .refPending(refPending), .ctl(ctl)
  );

  pageDramDp #(.ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .dramRdData(dramRdData), .reqHit(reqHit),
    .curWrite(curWrite), .dramAddr(dramAddr), .dramWrData(dramWrData),
    .rspValid(rspValid), .rspData(rspData)
  );

  assign dramRasN = ctl.rasN;
  assign dramCasN = ctl.casN;
  assign dramWeN  = ctl.weN;

endmodule

// File: rtl/pageDramCtrlChk.sv
module pageDramCtrlChk (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic rspValid,
  input logic dramRasN,
  input logic dramCasN,
  input logic dramWeN,
  input logic refPending
);

  logic [3:0] pendAge;

  always_ff @(posedge clk) begin
    if (!rstN) pendAge <= '0;
    else if (refPending) pendAge <= (pendAge == 4'hF) ? pendAge : pendAge + 1'b1;
    else pendAge <= '0;
  end

  assert_cas_after_ras_R3: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> (!dramRasN && $past(!dramRasN)));

  assert_we_with_cas_R10: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> !dramCasN);

  assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!dramCasN && dramWeN));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_ref_blocks_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    refPending |-> !reqReady);

  assert_ref_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    pendAge <= 4'd8);

  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> dramCasN);

endmodule

bind pageDramCtrl pageDramCtrlChk chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
  .refPending(refPending)
);

// File: tb/pageDramCtrl_tb_top.sv
`timescale 1ns/1ps
module pageDramCtrl_tb_top;

  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int REFI  = 40;
  localparam int ROWS  = 1 << ROW_W;
  localparam int WORDS = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic reqReady, rspValid, dramRasN, dramCasN, dramWeN;
  logic [5:0]  reqAddr = '0;
  logic [63:0] reqWdata = '0, rspData, dramWrData, dramRdData;
  logic [2:0]  dramAddr;

  always #2.5 clk = ~clk;

  pageDramCtrl #(.ROW_W(ROW_W), .COL_W(COL_W), .LANES(8), .LANE_W(8),
                 .REF_INTERVAL(REFI)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramWrData(dramWrData), .dramRdData(dramRdData)
  );

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Device model: eight byte-wide arrays
  logic [7:0]  devMem [8][WORDS];
  logic [63:0] shadow [WORDS];
  bit          mActv = 1'b0, casSeen = 1'b0;
  logic [2:0]  mRow = '0;
  int          refCount = 0, mainAct = 0, refExp = 0, cyc = 0, lastRef = -1;

  always_comb begin
    for (int k = 0; k < 8; k++)
      dramRdData[k*8 +: 8] = (!dramCasN && dramWeN) ? devMem[k][{mRow, dramAddr}] : 8'h00;
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rstN) begin
      if (dramRasN && mActv) begin
        mActv = 1'b0;
        if (!casSeen) begin
          check(mRow == refExp[2:0], "R6 refresh row order", 64'(mRow), 64'(refExp));
          if (lastRef >= 0)
            check((cyc - lastRef <= REFI + 8) && (cyc - lastRef >= REFI - 8),
                  "R7 refresh spacing", 64'(cyc - lastRef), 64'(REFI));
          lastRef = cyc;
          refExp = (refExp + 1) % ROWS;
          refCount++;
        end
      end
      if (!dramRasN && !mActv) begin
        mActv = 1'b1;
        mRow = dramAddr;
        casSeen = 1'b0;
      end
      if (!dramCasN) begin
        if (!casSeen) mainAct++;
        casSeen = 1'b1;
        if (!dramWeN)
          for (int k = 0; k < 8; k++) devMem[k][{mRow, dramAddr}] = dramWrData[k*8 +: 8];
      end
    end
  end

  task automatic doOp(input bit wr, input logic [5:0] a, input logic [63:0] d);
    int expLat, lat, gotLat;
    bit got;
    logic [63:0] rd;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    expLat = !mActv ? 3 : ((mRow == a[5:3]) ? 2 : 4);
    @(posedge clk);
    lat = 0; got = 1'b0; gotLat = 0; rd = '0;
    repeat (5) begin
      @(negedge clk);
      lat++;
      reqValid = 1'b0;
      if (rspValid && !got) begin got = 1'b1; gotLat = lat; rd = rspData; end
    end
    if (wr) begin
      check(!got, "R9 no response to write", 64'(got), 64'd0);
      shadow[a] = d;
    end else begin
      check(got && gotLat == expLat, (expLat == 2) ? "R4 hit latency" : "R5 miss latency",
            64'(gotLat), 64'(expLat));
      check(rd == shadow[a], "R2 read word", rd, shadow[a]);
    end
  endtask

  task automatic waitRefresh();
    int start = refCount;
    while (refCount == start) @(negedge clk);
  endtask

  initial begin
    int actBefore;
    logic [5:0] a;
    for (int i = 0; i < WORDS; i++) begin
      shadow[i] = '0;
      for (int k = 0; k < 8; k++) devMem[k][i] = 8'h00;
    end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R8 ready after reset", 64'(reqReady), 64'd1);
    check({dramRasN, dramCasN, dramWeN} == 3'b111, "R8 strobes idle after reset",
          64'({dramRasN, dramCasN, dramWeN}), 64'd7);
    check(!rspValid, "R9 no response after reset", 64'(rspValid), 64'd0);

    // R1/R2/R10: lane striping and address split
    doOp(1'b1, {3'd5, 3'd3}, 64'h8786858483828180);
    for (int k = 0; k < 8; k++)
      check(devMem[k][{3'd5, 3'd3}] == 8'h80 + 8'(k), "R1 R10 lane byte placement",
            64'(devMem[k][{3'd5, 3'd3}]), 64'(8'h80 + 8'(k)));
    doOp(1'b0, {3'd5, 3'd3}, '0);

    // R4: page hits right after a refresh
    waitRefresh();
    actBefore = mainAct;
    doOp(1'b1, {3'd2, 3'd0}, 64'h0123456789ABCDEF);
    doOp(1'b0, {3'd2, 3'd0}, '0);
    doOp(1'b1, {3'd2, 3'd7}, 64'hFEDCBA9876543210);
    doOp(1'b0, {3'd2, 3'd7}, '0);
    check(mainAct - actBefore == 1, "R4 single activation for same-row run",
          64'(mainAct - actBefore), 64'd1);

    // R5: row change
    waitRefresh();
    actBefore = mainAct;
    doOp(1'b0, {3'd3, 3'd1}, '0);
    doOp(1'b0, {3'd4, 3'd1}, '0);
    check(mainAct - actBefore == 2, "R5 activation per row change",
          64'(mainAct - actBefore), 64'd2);

    // Random mix, biased toward the open row
    a = '0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) < 6) a[2:0] = 3'($urandom_range(0, 7));
      else a = 6'($urandom_range(0, WORDS - 1));
      doOp(1'($urandom_range(0, 1)), a, {$urandom, $urandom});
    end

    check(refCount > ROWS, "R6 refresh rows wrapped", 64'(refCount), 64'(ROWS + 1));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule